// File: doc/BRIEF.md
# Video DAC Host Register Interface

This block is the processor-facing register file of a palette video converter. A host reaches every internal location through an 11-bit address register. It loads the register one byte at a time through two address ports, then moves 8-bit data through a data port. Write and read strobes are separate and each lasts one clock cycle. The block holds these locations:

- a constant identification byte;
- a pixel mask byte;
- a 10-bit command register;
- a five-byte control window;
- two colour entries with three components each;
- cursor image storage.

The mask and command values drive the pixel path directly.

The address register advances by itself only in certain regions. In the control window and in cursor space it steps after every data access, and it wraps from the top of cursor space to zero. In the colour window it steps only after the third access to an entry. A small state machine tracks the component sub-index with three states: RED, GREEN and BLUE. Its transitions are:

- RED→GREEN on a data access inside the colour window;
- GREEN→BLUE on a data access inside the colour window;
- BLUE→RED on a data access inside the colour window, and the address steps at the same time;
- any state→RED on a write to either address port.

Bit 3 of the command register enables writes to the upper address byte. While it is clear, the upper byte stays at zero.

Top module: `vdac_hostregs`

## Requirements
- R1: After reset the address is 000H, the pixel mask output is FFH, the command output is 000H and the sub-index is RED.
- R2: Port select 0 reads and writes address bits 7..0. Port select 1 reads and writes address bits 10..8 in data bits 2..0, and reads back zeros in data bits 7..3. A write through port select 1 changes the address only when command bit 3 is 1.
- R3: A data read at address 003H returns 79H, and a data write there changes nothing.
- R4: Address 004H is a read/write pixel mask whose value appears on the mask output.
- R5: A write to address 005H stores data bits 7..3 and 1..0 into command bits 7..3 and 1..0. Command bit 2 is forced to 0, and command bits 9..8 are always 0. A read returns command bits 7..0.
- R6: Addresses 200H to 204H are read/write bytes, and the address steps by one after each data access in that range.
- R7: Addresses 400H to 7FFH are cursor storage. The address steps after each data access there and goes from 7FFH to 000H. A location is aliased by the low address bits over the stored depth.
- R8: At 303H and 304H, successive data accesses address red, green and blue. The address is unchanged after red and green and steps by one after blue.
- R9: Any write to port select 0 or 1 returns the sub-index to RED.
- R10: A data read at an unmapped address, or any access on port select 3, returns 00H. Writes there are ignored, and the address does not step outside the windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 2 | Port select: 0 address low, 1 address high, 2 data, 3 unused |
| wr_stb | input | 1 | One-cycle write strobe |
| rd_stb | input | 1 | One-cycle read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_stb is high |
| pix_mask | output | 8 | Pixel mask to the pixel path |
| cmd_reg | output | 10 | Command register to the pixel path |

## Verification
In the colour window, the blue access falls in the same cycle as three other actions:

- the component write;
- the address increment;
- the return of the sub-index to RED.

The test writes red, green and blue at 303H and reads the address port between writes. It expects 303H after red and after green, and 304H after blue. It then reads the entry back from 303H, which shows that the blue write and the step did not disturb each other. A second overlap is the cursor wrap. A write at 7FFH must both store its byte and leave the address at 000H, and the test judges this by reading back both the address and the stored byte.

// File: rtl/vdac_pkg.sv
package vdac_pkg;
    localparam int AW   = 11;
    localparam int DW   = 8;
    localparam int CMDW = 10;
    localparam int HIW  = AW - 8;

    typedef enum logic [1:0] {
        PORT_ALO  = 2'd0,
        PORT_AHI  = 2'd1,
        PORT_DATA = 2'd2,
        PORT_NONE = 2'd3
    } port_e;

    typedef enum logic [1:0] {
        COMP_RED   = 2'd0,
        COMP_GREEN = 2'd1,
        COMP_BLUE  = 2'd2
    } comp_e;

    localparam logic [AW-1:0] ADDR_ID   = 11'h003;
    localparam logic [AW-1:0] ADDR_MASK = 11'h004;
    localparam logic [AW-1:0] ADDR_CMD  = 11'h005;
    localparam logic [AW-1:0] CTRL_LO   = 11'h200;
    localparam logic [AW-1:0] CTRL_HI   = 11'h204;
    localparam logic [AW-1:0] COL_LO    = 11'h303;
    localparam logic [AW-1:0] COL_HI    = 11'h304;
    localparam logic [AW-1:0] CUR_LO    = 11'h400;

    localparam int CTRL_N   = int'(CTRL_HI - CTRL_LO) + 1;
    localparam int COL_N    = int'(COL_HI - COL_LO) + 1;
    localparam int COMP_N   = 3;

    localparam logic [DW-1:0] ID_VALUE = 8'h79;
    localparam logic [DW-1:0] MASK_RST = 8'hFF;

    localparam int CMD_HIEN_BIT = 3;
    localparam int CMD_ZERO_BIT = 2;
endpackage

// File: rtl/vdac_addr_ctrl.sv
module vdac_addr_ctrl
    import vdac_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic          hi_en,
    input  logic          data_acc,
    input  logic [DW-1:0] wdata,
    output logic [AW-1:0] addr_q,
    output comp_e         comp_q,
    output logic          in_ctrl,
    output logic          in_col,
    output logic          in_cur
);
    logic [AW-1:0] addr_d;
    comp_e         comp_d;

    always_comb begin
        in_ctrl = (addr_q >= CTRL_LO) && (addr_q <= CTRL_HI);
        in_col  = (addr_q >= COL_LO)  && (addr_q <= COL_HI);
        in_cur  = (addr_q >= CUR_LO);
    end

    // address next value
    always_comb begin
        addr_d = addr_q;
        if (wr_lo) begin
            addr_d[7:0] = wdata;
        end else if (wr_hi) begin
            if (hi_en) addr_d[AW-1:8] = wdata[HIW-1:0];
        end else if (data_acc) begin
            if (in_ctrl || in_cur)
                addr_d = addr_q + 1'b1;
            else if (in_col && comp_q == COMP_BLUE)
                addr_d = addr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    // component state register
    always_ff @(posedge clk) begin
        if (!rst_n) comp_q <= COMP_RED;
        else        comp_q <= comp_d;
    end

    // component next state
    always_comb begin
        comp_d = comp_q;
        if (wr_lo || wr_hi) begin
            comp_d = COMP_RED;
        end else if (data_acc && in_col) begin
            unique case (comp_q)
                COMP_RED:   comp_d = COMP_GREEN;
                COMP_GREEN: comp_d = COMP_BLUE;
                COMP_BLUE:  comp_d = COMP_RED;
                default:    comp_d = COMP_RED;
            endcase
        end
    end

    AST_NO_INC_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !in_ctrl && !in_cur && !in_col) |=> addr_q == $past(addr_q)); // R10
    AST_CUR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && addr_q == '1) |=> addr_q == '0); // R7
    AST_HI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !hi_en) |=> addr_q == $past(addr_q)); // R2
    AST_RG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && in_col && comp_q != COMP_BLUE) |=> addr_q == $past(addr_q)); // R8
    AST_BLUE_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && in_col && comp_q == COMP_BLUE)
            |=> (addr_q == $past(addr_q) + 1'b1) && (comp_q == COMP_RED)); // R8
    AST_SUB_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo || wr_hi) |=> comp_q == COMP_RED); // R9
endmodule

// File: rtl/vdac_reg_bank.sv
module vdac_reg_bank
    import vdac_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_data,
    input  logic [AW-1:0]   addr,
    input  logic            in_ctrl,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   mask_q,
    output logic [CMDW-1:0] cmd_q,
    output logic [DW-1:0]   rd_val,
    output logic            rd_hit
);
    localparam int CIW = $clog2(CTRL_N);

    logic [DW-1:0]  ctrl_q [CTRL_N];
    logic [AW-1:0]  ctrl_off;
    logic [CIW-1:0] ctrl_idx;

    always_comb begin
        ctrl_off = addr - CTRL_LO;
        ctrl_idx = ctrl_off[CIW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= MASK_RST;
            cmd_q  <= '0;
        end else if (wr_data) begin
            if (addr == ADDR_MASK) mask_q <= wdata;
            if (addr == ADDR_CMD) begin
                cmd_q                 <= {2'b00, wdata};
                cmd_q[CMD_ZERO_BIT]   <= 1'b0;
            end
        end
    end

    generate
        for (genvar gi = 0; gi < CTRL_N; gi++) begin : g_ctrl
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ctrl_q[gi] <= '0;
                else if (wr_data && in_ctrl && ctrl_idx == CIW'(gi))
                    ctrl_q[gi] <= wdata;
            end
        end
    endgenerate

    always_comb begin
        rd_val = '0;
        rd_hit = 1'b1;
        if (addr == ADDR_ID)        rd_val = ID_VALUE;
        else if (addr == ADDR_MASK) rd_val = mask_q;
        else if (addr == ADDR_CMD)  rd_val = cmd_q[DW-1:0];
        else if (in_ctrl)           rd_val = ctrl_q[ctrl_idx];
        else                        rd_hit = 1'b0;
    end

    AST_CMD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && addr == ADDR_CMD)
            |=> (cmd_q[7:3] == $past(wdata[7:3])) && (cmd_q[1:0] == $past(wdata[1:0]))); // R5
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && addr != ADDR_MASK) |=> mask_q == $past(mask_q)); // R4
endmodule

// File: rtl/vdac_store.sv
module vdac_store
    import vdac_pkg::*;
#(
    parameter int CUR_WORDS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_data,
    input  logic [AW-1:0] addr,
    input  logic          in_cur,
    input  logic          in_col,
    input  comp_e         comp,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cur_rd,
    output logic [DW-1:0] col_rd
);
    localparam int CW = $clog2(CUR_WORDS);
    localparam int EW = (COL_N > 1) ? $clog2(COL_N) : 1;

    logic [DW-1:0] cur_q [CUR_WORDS];
    logic [DW-1:0] col_q [COL_N][COMP_N];
    logic [CW-1:0] cur_idx;
    logic [AW-1:0] col_off;
    logic [EW-1:0] ent;

    always_comb begin
        cur_idx = addr[CW-1:0];
        col_off = addr - COL_LO;
        ent     = col_off[EW-1:0];
    end

    generate
        for (genvar gc = 0; gc < CUR_WORDS; gc++) begin : g_cur
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cur_q[gc] <= '0;
                else if (wr_data && in_cur && cur_idx == CW'(gc))
                    cur_q[gc] <= wdata;
            end
        end
        for (genvar ge = 0; ge < COL_N; ge++) begin : g_ent
            for (genvar gk = 0; gk < COMP_N; gk++) begin : g_comp
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        col_q[ge][gk] <= '0;
                    else if (wr_data && in_col && ent == EW'(ge) && comp == comp_e'(gk))
                        col_q[ge][gk] <= wdata;
                end
            end
        end
    endgenerate

    always_comb begin
        cur_rd = cur_q[cur_idx];
        col_rd = '0;
        if (in_col && comp != 2'd3) col_rd = col_q[ent][comp];
    end
endmodule

// File: rtl/vdac_hostregs.sv
module vdac_hostregs
    import vdac_pkg::*;
#(
    parameter int CUR_WORDS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  sel,
    input  logic        wr_stb,
    input  logic        rd_stb,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic [7:0]  pix_mask,
    output logic [9:0]  cmd_reg
);
    port_e           port;
    logic            wr_lo, wr_hi, wr_data, data_acc;
    logic [AW-1:0]   addr;
    comp_e           comp;
    logic            in_ctrl, in_col, in_cur;
    logic [DW-1:0]   bank_rd, cur_rd, col_rd;
    logic            bank_hit;
    logic [CMDW-1:0] cmd_q;

    always_comb begin
        port     = port_e'(sel);
        wr_lo    = wr_stb && port == PORT_ALO;
        wr_hi    = wr_stb && port == PORT_AHI;
        wr_data  = wr_stb && port == PORT_DATA;
        data_acc = (wr_stb || rd_stb) && port == PORT_DATA;
    end

    vdac_addr_ctrl u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .hi_en    (cmd_q[CMD_HIEN_BIT]),
        .data_acc (data_acc),
        .wdata    (wdata),
        .addr_q   (addr),
        .comp_q   (comp),
        .in_ctrl  (in_ctrl),
        .in_col   (in_col),
        .in_cur   (in_cur)
    );

    vdac_reg_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_data (wr_data),
        .addr    (addr),
        .in_ctrl (in_ctrl),
        .wdata   (wdata),
        .mask_q  (pix_mask),
        .cmd_q   (cmd_q),
        .rd_val  (bank_rd),
        .rd_hit  (bank_hit)
    );

    vdac_store #(.CUR_WORDS(CUR_WORDS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_data (wr_data),
        .addr    (addr),
        .in_cur  (in_cur),
        .in_col  (in_col),
        .comp    (comp),
        .wdata   (wdata),
        .cur_rd  (cur_rd),
        .col_rd  (col_rd)
    );

    assign cmd_reg = cmd_q;

    always_comb begin
        rdata = '0;
        unique case (port)
            PORT_ALO:  rdata = addr[7:0];
            PORT_AHI:  rdata = {{(DW-HIW){1'b0}}, addr[AW-1:8]};
            PORT_DATA: begin
                if (in_cur)        rdata = cur_rd;
                else if (in_col)   rdata = col_rd;
                else if (bank_hit) rdata = bank_rd;
                else               rdata = '0;
            end
            default:   rdata = '0;
        endcase
    end

    AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && port == PORT_DATA && addr == ADDR_ID) |-> rdata == ID_VALUE); // R3
    AST_UNUSED_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && port == PORT_NONE) |-> rdata == '0); // R10
endmodule

// File: tb/tb_vdac_hostregs.sv
module tb_vdac_hostregs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       wr_stb = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pix_mask;
    logic [9:0] cmd_reg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [1:0] S_LO = 2'd0, S_HI = 2'd1, S_DAT = 2'd2, S_NONE = 2'd3;

    always #10 clk = ~clk;

    vdac_hostregs dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .wdata(wdata), .rdata(rdata), .pix_mask(pix_mask), .cmd_reg(cmd_reg)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        sel = s; wdata = d; wr_stb = 1'b1;
        @(posedge clk); #1;
        wr_stb = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk);
        sel = s; rd_stb = 1'b1;
        #2 d = rdata;
        @(posedge clk); #1;
        rd_stb = 1'b0;
    endtask

    task automatic set_addr(input logic [10:0] a);
        bus_wr(S_HI, {5'b0, a[10:8]});
        bus_wr(S_LO, a[7:0]);
    endtask

    task automatic chk_addr(input string tag, input logic [10:0] exp);
        logic [7:0] lo, hi;
        bus_rd(S_LO, lo);
        bus_rd(S_HI, hi);
        chk(tag, {hi, lo}, {5'b0, exp});
    endtask

    task automatic t_reset;
        chk("R1 mask", pix_mask, 8'hFF);
        chk("R1 cmd", cmd_reg, 10'h000);
        chk_addr("R1 addr", 11'h000);
    endtask

    task automatic t_id;
        logic [7:0] d;
        set_addr(11'h003);
        bus_rd(S_DAT, d); chk("R3 id read", d, 8'h79);
        bus_wr(S_DAT, 8'h55);
        bus_rd(S_DAT, d); chk("R3 id after write", d, 8'h79);
        chk_addr("R10 no step at id", 11'h003);
    endtask

    task automatic t_mask;
        logic [7:0] d;
        set_addr(11'h004);
        bus_wr(S_DAT, 8'hA5);
        chk("R4 mask out", pix_mask, 8'hA5);
        bus_rd(S_DAT, d); chk("R4 mask read", d, 8'hA5);
    endtask

    task automatic t_cmd;
        logic [7:0] d;
        set_addr(11'h005);
        bus_wr(S_DAT, 8'hFF);
        chk("R5 cmd out", cmd_reg, 10'h0FB);
        bus_rd(S_DAT, d); chk("R5 cmd read", d, 8'hFB);
    endtask

    task automatic t_hibyte;
        logic [7:0] d;
        bus_wr(S_HI, 8'h02);
        bus_rd(S_HI, d); chk("R2 hi enabled", d, 8'h02);
        set_addr(11'h005);
        bus_wr(S_DAT, 8'h00);
        chk("R5 cmd cleared", cmd_reg, 10'h000);
        bus_wr(S_HI, 8'h07);
        bus_rd(S_HI, d); chk("R2 hi gated", d, 8'h00);
        bus_rd(S_LO, d); chk("R2 lo kept", d, 8'h05);
        bus_wr(S_DAT, 8'h08);
        chk("R2 hi enable set", cmd_reg, 10'h008);
    endtask

    task automatic t_ctrl;
        logic [7:0] d;
        set_addr(11'h200);
        for (int i = 0; i < 5; i++) bus_wr(S_DAT, 8'h11 + 8'(i));
        chk_addr("R6 after writes", 11'h205);
        set_addr(11'h200);
        for (int i = 0; i < 5; i++) begin
            bus_rd(S_DAT, d); chk("R6 ctrl read", d, 8'h11 + 8'(i));
        end
        chk_addr("R6 after reads", 11'h205);
        bus_rd(S_DAT, d); chk("R10 unmapped read", d, 8'h00);
        chk_addr("R10 no step", 11'h205);
    endtask

    task automatic t_cursor;
        logic [7:0] d;
        set_addr(11'h7FE);
        bus_wr(S_DAT, 8'hC1);
        bus_wr(S_DAT, 8'hC2);
        chk_addr("R7 wrap", 11'h000);
        set_addr(11'h7FE);
        bus_rd(S_DAT, d); chk("R7 cursor 7FE", d, 8'hC1);
        bus_rd(S_DAT, d); chk("R7 cursor 7FF", d, 8'hC2);
        chk_addr("R7 wrap on read", 11'h000);
        set_addr(11'h40E);
        bus_rd(S_DAT, d); chk("R7 alias", d, 8'hC1);
    endtask

    task automatic t_color;
        logic [7:0] d;
        set_addr(11'h303);
        bus_wr(S_DAT, 8'h10); chk_addr("R8 after red", 11'h303);
        bus_wr(S_DAT, 8'h20); chk_addr("R8 after green", 11'h303);
        bus_wr(S_DAT, 8'h30); chk_addr("R8 after blue", 11'h304);
        bus_wr(S_DAT, 8'h40);
        bus_wr(S_DAT, 8'h50);
        bus_wr(S_DAT, 8'h60);
        chk_addr("R8 after second entry", 11'h305);
        set_addr(11'h303);
        bus_rd(S_DAT, d); chk("R8 red", d, 8'h10);
        bus_rd(S_DAT, d); chk("R8 green", d, 8'h20);
        bus_rd(S_DAT, d); chk("R8 blue", d, 8'h30);
        bus_rd(S_DAT, d); chk("R8 entry2 red", d, 8'h40);
    endtask

    task automatic t_subreset;
        logic [7:0] d;
        set_addr(11'h303);
        bus_wr(S_DAT, 8'h77);
        bus_wr(S_DAT, 8'h88);
        bus_wr(S_LO, 8'h03);
        bus_wr(S_DAT, 8'h99);
        chk_addr("R9 addr held", 11'h303);
        bus_wr(S_LO, 8'h03);
        bus_rd(S_DAT, d); chk("R9 red rewritten", d, 8'h99);
        bus_rd(S_DAT, d); chk("R9 green kept", d, 8'h88);
        bus_rd(S_DAT, d); chk("R9 blue kept", d, 8'h30);
    endtask

    task automatic t_unmapped;
        logic [7:0] d;
        set_addr(11'h006);
        bus_wr(S_DAT, 8'h3C);
        chk("R10 mask untouched", pix_mask, 8'hA5);
        chk("R10 cmd untouched", cmd_reg, 10'h008);
        bus_rd(S_DAT, d); chk("R10 read zero", d, 8'h00);
        bus_wr(S_NONE, 8'hEE);
        bus_rd(S_NONE, d); chk("R10 port3 zero", d, 8'h00);
        chk_addr("R10 addr kept", 11'h006);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_id();
        t_mask();
        t_cmd();
        t_hibyte();
        t_ctrl();
        t_cursor();
        t_color();
        t_subreset();
        t_unmapped();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule